// File: doc/BRIEF.md
# Counting Semaphore Cell

A hardware counting semaphore that threads on a shared fabric use to synchronise. A requester reaches the cell through one of three access views, selected by a 4-bit view code on each access. A read in either "take" view performs P. It returns the count as it stood before the access and lowers the count by one if the count was above zero. A write in either take view performs V. It raises the count by one, saturating at 0xFFFF, and carries no data. The raw view reads the count without disturbing it, and a raw write does nothing.

When a blocking P finds the count at zero, the cell raises a stall flag in its response and records the requester's ID in a waiter set. The next V releases every recorded waiter at once through a one-cycle wake mask and empties the set. A released requester is expected to retry its P, so with several waiters and one increment only the first retry succeeds. The non-blocking P on a zero count answers zero and changes nothing. Address decoding and the suspension of the requesting processor live outside this block.

Accesses are plain strobes with no back-pressure: the cell accepts one access every cycle and never refuses one. The response (`rsp_valid`, `rsp_data`, `rsp_stall`) is registered and appears in the cycle after the access. A stalled response asks the requester, not the cell, to wait.

Top module: `sema_cell`

## Requirements
- R1: A read with view code 4 (take-wait) or 5 (take-try) on a nonzero count gives, one cycle later, `rsp_valid`=1, `rsp_stall`=0 and `rsp_data` equal to the count before the access, and lowers the count by one.
- R2: A read with view code 4 on a zero count gives, one cycle later, `rsp_valid`=1, `rsp_stall`=1 and `rsp_data`=0, sets bit `acc_id` of the waiter set, and leaves the count at zero.
- R3: A read with view code 5 on a zero count gives, one cycle later, `rsp_valid`=1, `rsp_stall`=0 and `rsp_data`=0, and changes neither the count nor the waiter set.
- R4: A write with view code 4 or 5 raises the count by one, holding at 0xFFFF once there; the two codes behave the same.
- R5: Every write with view code 4 or 5 drives `wake_mask` for one cycle, in the next cycle, with the waiter set (bit i stands for requester i) and empties the set; at all other times `wake_mask` is zero.
- R6: A read with view code 0 (raw) returns the count one cycle later with `rsp_stall`=0 and leaves it unchanged; a write with view code 0 changes nothing.
- R7: After reset the count is zero, the waiter set is empty and all outputs are zero.
- R8: Bits of `rsp_data` above bit 15 are always zero.
- R9: When `acc_rd` and `acc_wr` are both high, only the read takes effect.
- R10: A read with any view code other than 0, 4 or 5 produces no response (`rsp_valid`=0), and a write with such a code changes nothing.
- R11: With two waiters and one V, the first waiter to retry its take-wait read succeeds and the second stalls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_view | input | 4 | View code: 0 raw, 4 take-wait, 5 take-try |
| acc_rd | input | 1 | Read strobe for this cycle |
| acc_wr | input | 1 | Write strobe for this cycle |
| acc_id | input | ID_W (3) | Requester ID of the access |
| rsp_valid | output | 1 | A read response is present |
| rsp_data | output | DATA_W (64) | Read value, count zero-extended |
| rsp_stall | output | 1 | The take-wait read found zero; the requester must wait |
| wake_mask | output | NUM_REQ (8) | One-cycle pulse releasing recorded waiters |

## Verification
Every result of this cell is due exactly one clock after the access that causes it. This covers the read value, the stall flag, the wake pulse that follows a V, and the count change that a later raw read exposes. The bench drives each access just after a falling edge. A behavioural model updates on the following rising edge, and the design's outputs are compared with the model at the next falling edge, which is one full response latency later. The comparison runs in every cycle, including idle ones, so a wake pulse that lasts too long or a response for an ignored view is caught in the cycle it appears.

// File: rtl/sema_pkg.sv
`timescale 1ns/1ps
package sema_pkg;
  localparam int VIEW_W = 4;

  localparam logic [VIEW_W-1:0] VW_RAW       = 4'd0;
  localparam logic [VIEW_W-1:0] VW_TAKE_WAIT = 4'd4;
  localparam logic [VIEW_W-1:0] VW_TAKE_TRY  = 4'd5;

  typedef struct packed {
    logic peek;       // raw read
    logic take_wait;  // blocking P
    logic take_try;   // non-blocking P
    logic give;       // V
  } cell_op_t;
endpackage

// File: rtl/sema_decode.sv
`timescale 1ns/1ps
module sema_decode
  import sema_pkg::*;
(
  input  logic [VIEW_W-1:0] view,
  input  logic              rd,
  input  logic              wr,
  output cell_op_t          op
);
  logic is_raw, is_wait, is_try;

  always_comb begin
    is_raw  = (view == VW_RAW);
    is_wait = (view == VW_TAKE_WAIT);
    is_try  = (view == VW_TAKE_TRY);
    op.peek      = rd & is_raw;
    op.take_wait = rd & is_wait;
    op.take_try  = rd & is_try;
    // a read in the same cycle masks the write
    op.give      = wr & ~rd & (is_wait | is_try);
  end
endmodule

// File: rtl/sema_count.sv
`timescale 1ns/1ps
module sema_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_req,
  input  logic             inc_req,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  always_comb begin
    is_zero = (cnt_q == '0);
    at_max  = (cnt_q == CNT_MAX);
    cnt     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (dec_req && !is_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (inc_req && !at_max) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sema_waitset.sv
`timescale 1ns/1ps
module sema_waitset #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               park_en,
  input  logic [ID_W-1:0]    park_id,
  input  logic               release_en,
  output logic [NUM_REQ-1:0] wake_mask
);
  logic [NUM_REQ-1:0] park_q;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic hit;
    assign hit = park_en && (park_id == ID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        park_q[i]    <= 1'b0;
        wake_mask[i] <= 1'b0;
      end else begin
        wake_mask[i] <= release_en & park_q[i];
        if (release_en) begin
          park_q[i] <= 1'b0;
        end else if (hit) begin
          park_q[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sema_cell.sv
`timescale 1ns/1ps
module sema_cell
  import sema_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 64,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VIEW_W-1:0]  acc_view,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [ID_W-1:0]    acc_id,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_stall,
  output logic [NUM_REQ-1:0] wake_mask
);
  localparam int PAD_W = DATA_W - CNT_W;

  cell_op_t         op;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  logic             any_take;
  logic             park;
  logic             any_read;

  sema_decode u_dec (
    .view (acc_view),
    .rd   (acc_rd),
    .wr   (acc_wr),
    .op   (op)
  );

  always_comb begin
    any_take = op.take_wait | op.take_try;
    park     = op.take_wait & cnt_zero;
    any_read = op.peek | any_take;
  end

  sema_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_req (any_take),
    .inc_req (op.give),
    .cnt     (cnt_q),
    .is_zero (cnt_zero)
  );

  sema_waitset #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .park_en    (park),
    .park_id    (acc_id),
    .release_en (op.give),
    .wake_mask  (wake_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= any_read;
      rsp_stall <= park;
      rsp_data  <= any_read ? {{PAD_W{1'b0}}, cnt_q} : '0;
    end
  end
endmodule

// File: rtl/sema_cell_chk.sv
`timescale 1ns/1ps
module sema_cell_chk
  import sema_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VIEW_W-1:0]  acc_view,
  input logic               acc_rd,
  input logic               acc_wr,
  input logic [CNT_W-1:0]   cnt,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               rsp_stall,
  input logic [NUM_REQ-1:0] wake_mask
);
  logic take_v, known_v;
  assign take_v  = (acc_view == VW_TAKE_WAIT) || (acc_view == VW_TAKE_TRY);
  assign known_v = take_v || (acc_view == VW_RAW);

  AST_TAKE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && take_v && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && !rsp_stall); // R1
  AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_view == VW_TAKE_WAIT && cnt == '0) |=> rsp_stall && rsp_data == '0 && cnt == '0); // R2
  AST_TRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_view == VW_TAKE_TRY && cnt == '0) |=> rsp_valid && !rsp_stall && cnt == '0); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_rd && take_v && cnt == {CNT_W{1'b1}}) |=> cnt == {CNT_W{1'b1}}); // R4
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mask != '0) |=> wake_mask == '0); // R5
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && acc_view == VW_RAW) |=> $stable(cnt)); // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_data[DATA_W-1:CNT_W] == '0); // R8
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && !known_v) |=> !rsp_valid && $stable(cnt)); // R10
  AST_STALL_IS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> rsp_valid); // R2
endmodule

bind sema_cell sema_cell_chk #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_view  (acc_view),
  .acc_rd    (acc_rd),
  .acc_wr    (acc_wr),
  .cnt       (cnt_q),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_stall (rsp_stall),
  .wake_mask (wake_mask)
);

// File: tb/sema_cell_test.sv
`timescale 1ns/1ps
module sema_cell_test;
  localparam int NREQ = 8;
  localparam int IDW  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       acc_view = 4'd0;
  logic             acc_rd = 1'b0;
  logic             acc_wr = 1'b0;
  logic [IDW-1:0]   acc_id = '0;
  logic             rsp_valid;
  logic [63:0]      rsp_data;
  logic             rsp_stall;
  logic [NREQ-1:0]  wake_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string cur_tag = "R7";

  // reference model state
  int              m_cnt = 0;
  logic [NREQ-1:0] m_wait = '0;
  logic            e_valid = 0;
  logic            e_stall = 0;
  longint unsigned e_data = 0;
  logic [NREQ-1:0] e_wake = '0;

  sema_cell uut (
    .clk(clk), .rst_n(rst_n), .acc_view(acc_view), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_id(acc_id), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_stall(rsp_stall), .wake_mask(wake_mask)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_wait = '0; e_valid = 0; e_stall = 0; e_data = 0; e_wake = '0;
    end else begin
      e_valid = 0; e_stall = 0; e_data = 0; e_wake = '0;
      if (acc_rd) begin
        if (acc_view == 4'd0) begin
          e_valid = 1; e_data = m_cnt;
        end else if (acc_view == 4'd4 || acc_view == 4'd5) begin
          e_valid = 1;
          if (m_cnt > 0) begin
            e_data = m_cnt; m_cnt = m_cnt - 1;
          end else if (acc_view == 4'd4) begin
            e_stall = 1; m_wait[acc_id] = 1'b1;
          end
        end
      end else if (acc_wr && (acc_view == 4'd4 || acc_view == 4'd5)) begin
        if (m_cnt < 65535) m_cnt = m_cnt + 1;
        e_wake = m_wait; m_wait = '0;
      end
    end
  end

  task automatic compare(input string tag);
    total++;
    if (rsp_valid !== e_valid || rsp_stall !== e_stall || rsp_data !== e_data || wake_mask !== e_wake) begin
      bad++;
      $display("FAIL %s: valid/stall/data/wake actual=%0b/%0b/%h/%b expected=%0b/%0b/%h/%b",
               tag, rsp_valid, rsp_stall, rsp_data, wake_mask, e_valid, e_stall, e_data, e_wake);
    end
  endtask

  task automatic step(input logic [3:0] v, input logic r, input logic w, input int id, input string tag);
    @(negedge clk);
    compare(cur_tag);
    acc_view = v; acc_rd = r; acc_wr = w; acc_id = id[IDW-1:0]; cur_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(4'd0, 1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R7");                       // reset state of outputs
    step(4'd0, 1, 0, 0, "R7");        // count reads zero after reset
    step(4'd4, 0, 1, 0, "R4");
    step(4'd5, 0, 1, 0, "R4");        // both take views give
    step(4'd4, 0, 1, 0, "R4");
    step(4'd0, 1, 0, 0, "R6");        // raw read 3, unchanged
    step(4'd0, 1, 0, 0, "R6");
    step(4'd0, 0, 1, 0, "R6");        // raw write ignored
    step(4'd0, 1, 0, 0, "R6");
    step(4'd5, 1, 0, 0, "R1");        // try take returns 3
    step(4'd4, 1, 0, 0, "R1");        // wait take returns 2
    step(4'd4, 1, 0, 0, "R1");        // returns 1
    step(4'd5, 1, 0, 3, "R3");        // try on zero
    step(4'd0, 1, 0, 0, "R3");
    step(4'd4, 1, 0, 1, "R2");        // waiters 1,2,5
    step(4'd4, 1, 0, 2, "R2");
    step(4'd4, 1, 0, 5, "R2");
    step(4'd0, 1, 0, 0, "R2");
    step(4'd5, 0, 1, 0, "R5");        // wake mask 0b00100110
    idle("R5");
    idle("R5");
    step(4'd4, 1, 0, 1, "R11");       // first retry wins
    step(4'd4, 1, 0, 2, "R11");       // second stalls again
    step(4'd4, 0, 1, 0, "R11");       // wakes requester 2 only
    idle("R11");
    step(4'd4, 1, 1, 3, "R9");        // read wins over write
    step(4'd4, 1, 1, 3, "R9");
    step(4'd0, 1, 0, 0, "R9");
    step(4'd7, 1, 0, 0, "R10");       // unknown view read: no response
    step(4'd9, 0, 1, 0, "R10");       // unknown view write ignored
    step(4'd0, 1, 0, 0, "R10");
    for (int k = 0; k < 65540; k++) step(4'd5, 0, 1, 0, "R4");
    step(4'd0, 1, 0, 0, "R4");        // held at 0xFFFF
    step(4'd5, 1, 0, 0, "R8");        // full count, upper bits zero
    step(4'd0, 1, 0, 0, "R8");
    for (int k = 0; k < 65540; k++) step(4'd5, 1, 0, 0, "R1");
    for (int k = 0; k < 3000; k++) begin
      int sel;
      logic [3:0] v;
      sel = int'($urandom_range(0, 3));
      v = (sel == 0) ? 4'd0 : (sel == 1) ? 4'd4 : (sel == 2) ? 4'd5 : 4'd6;
      step(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, NREQ-1)), "R1");
    end
    idle("R5");
    idle("R5");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule